// File: doc/BRIEF.md
# XOR Backpropagation Trainer

This block trains a tiny feed-forward network with two inputs, two hidden neurons and one output neuron until it reproduces the exclusive-OR of its inputs. All values are signed 16-bit fixed point with 12 fraction bits. For each of the four input patterns the block runs a forward pass through sigmoid neurons and forms the output error. It carries that error back to the hidden layer and adjusts all six weights by a learning rate. Every arithmetic step goes through one shared multiplier, driven by a 27-step schedule per pattern.

A start pulse reloads a fixed set of seed weights and begins training. After each pass over the truth table, the squared error summed over that pass is compared with a limit. Training stops with `done` high when the error is below the limit or when the pass count reaches a parameterised cap. The trained weights can be read at any time through a small combinational read port.

Top module: `xor_bp_trainer`

## Requirements
- R1: After reset, `done` is 0. The weights read back as the seeds w0=2048, w1=-1024, w2=-1536, w3=2867, w4=1229 and w5=-819. Read addresses 6 and 7 return 0.
- R2: A `start` seen while idle reloads the seeds and begins a new run, and the seeds can be read one cycle later. A `start` seen while a run is in progress has no effect on the run's length or its final weights.
- R3: Arithmetic uses Q4.12 signed 16-bit values. A product is (a*b) shifted right arithmetically by 12, which floors the result, and is then saturated to [-32768, 32767]. Every sum is saturated to the same range.
- R4: The sigmoid of a 16-bit sum s is read from 64 bins of width 0.25 over [-8, 8). The bin index is floor(s/1024)+32, and each entry is round(4096/(1+exp(-c))), where c is the centre of that bin.
- R5: Patterns run in the order (x0,x1) = (0,0), (0,1), (1,0), (1,1), with inputs encoded as 0 or 4096 and target x0 XOR x1. Hidden neuron 0 weighs x0 and x1 with w0 and w1, hidden neuron 1 uses w2 and w3, and the output neuron weighs the two hidden outputs with w4 and w5. Read address k returns weight wk.
- R6: With e = target - y, the squared error e*e is added to the pass error, and the output delta is (e*y)*(4096-y).
- R7: The delta for hidden neuron j is ((w_out_j * output delta) * h_j) * (4096 - h_j). The weight w_out_j is the value held before this pattern's updates.
- R8: Each weight gains learning_rate * (delta * source), where the delta and source are those of the weight's destination neuron and source, and the result is saturated.
- R9: At the end of each pass, `done` rises if the pass error is below `err_limit` (signed, strict) or if the pass count has reached MAX_EPOCHS. Otherwise the pass error is cleared and training continues.
- R10: A pass takes exactly 108 cycles. `done` rises at the clock edge 108*N cycles after the edge that accepted `start`, where N is the number of passes, and stays high until the next accepted `start`.
- R11: `rd_data` follows `rd_addr` combinationally. While idle, the weights do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a training run when idle |
| learn_rate | input | 16 | Learning rate, Q4.12 signed; hold stable during a run |
| err_limit | input | 16 | Pass error limit, Q4.12 signed; hold stable during a run |
| rd_addr | input | 3 | Weight select, 0 to 5 |
| rd_data | output | 16 | Selected weight, Q4.12 signed |
| done | output | 1 | Training finished |

## Verification
Each run is scored against an independent software model of the schedule. That model predicts the number of passes N, so `done` is expected in exactly the cycle 108*N edges after the accepting edge. The bench counts falling edges from that edge and compares the count at the first high `done`. The seeds are read one edge after `start`, because no weight is written until the 17th step. Final weights are read only once the block is idle, when the read port is stable.

// File: rtl/xor_bp_trainer.sv
`timescale 1ns/1ps
module xor_bp_trainer #(
  parameter int MAX_EPOCHS = 8192
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic signed [15:0] learn_rate,
  input  logic signed [15:0] err_limit,
  input  logic        [2:0]  rd_addr,
  output logic signed [15:0] rd_data,
  output logic               done
);
  localparam int EW = $clog2(MAX_EPOCHS + 1);
  localparam logic signed [15:0] ONE = 16'sd4096;

  typedef logic signed [15:0] q_t;

  function automatic q_t seed(input int i);
    case (i)
      0: return 16'sd2048;
      1: return -16'sd1024;
      2: return -16'sd1536;
      3: return 16'sd2867;
      4: return 16'sd1229;
      default: return -16'sd819;
    endcase
  endfunction

  function automatic q_t sat(input logic signed [31:0] v);
    if (v > 32'sd32767) return 16'sh7fff;
    if (v < -32'sd32768) return 16'sh8000;
    return v[15:0];
  endfunction

  function automatic logic [11:0] lut_neg(input logic [4:0] k);
    case (k)
      5'd0: return 12'd2;     5'd1: return 12'd2;     5'd2: return 12'd3;     5'd3: return 12'd3;
      5'd4: return 12'd4;     5'd5: return 12'd5;     5'd6: return 12'd7;     5'd7: return 12'd9;
      5'd8: return 12'd11;    5'd9: return 12'd15;    5'd10: return 12'd19;   5'd11: return 12'd24;
      5'd12: return 12'd31;   5'd13: return 12'd40;   5'd14: return 12'd51;   5'd15: return 12'd65;
      5'd16: return 12'd83;   5'd17: return 12'd106;  5'd18: return 12'd136;  5'd19: return 12'd172;
      5'd20: return 12'd219;  5'd21: return 12'd277;  5'd22: return 12'd349;  5'd23: return 12'd437;
      5'd24: return 12'd545;  5'd25: return 12'd674;  5'd26: return 12'd827;  5'd27: return 12'd1004;
      5'd28: return 12'd1205; 5'd29: return 12'd1428; 5'd30: return 12'd1668; default: return 12'd1920;
    endcase
  endfunction

  function automatic q_t sig(input q_t s);
    if (s[15]) return q_t'({4'b0, lut_neg(s[14:10])});
    return ONE - q_t'({4'b0, lut_neg(~s[14:10])});
  endfunction

  q_t w [6];
  q_t tmp, h0, h1, y, dout, dh0, dh1, err;
  logic busy;
  logic [4:0] step;
  logic [1:0] pat;
  logic [EW-1:0] epoch;

  q_t ma, mb, mres, e, xq0, xq1, fdelta, finput;
  logic signed [31:0] prod;
  logic [4:0] us;
  logic [2:0] ui, j;

  assign xq0 = pat[1] ? ONE : 16'sd0;
  assign xq1 = pat[0] ? ONE : 16'sd0;
  assign e   = ((pat[1] ^ pat[0]) ? ONE : 16'sd0) - y;
  assign us  = step - 5'd15;
  assign j   = us[3:1];
  assign ui  = (j < 3'd2) ? j + 3'd4 : j - 3'd2;
  assign fdelta = ui[2] ? dout : (ui[1] ? dh1 : dh0);
  assign finput = (ui == 3'd4) ? h0 : (ui == 3'd5) ? h1 : (ui[0] ? xq1 : xq0);
  assign prod = 32'(ma) * 32'(mb);
  assign mres = sat(prod >>> 12);
  assign rd_data = (rd_addr < 3'd6) ? w[rd_addr] : 16'sd0;

  always_comb begin
    ma = 16'sd0;
    mb = 16'sd0;
    if (step < 5'd6) begin
      ma = w[step[2:0]];
      mb = step[2] ? (step[0] ? h1 : h0) : (step[0] ? xq1 : xq0);
    end else begin
      case (step)
        5'd6:  begin ma = e;     mb = e;        end
        5'd7:  begin ma = e;     mb = y;        end
        5'd8:  begin ma = tmp;   mb = ONE - y;  end
        5'd9:  begin ma = w[4];  mb = dout;     end
        5'd10: begin ma = tmp;   mb = h0;       end
        5'd11: begin ma = tmp;   mb = ONE - h0; end
        5'd12: begin ma = w[5];  mb = dout;     end
        5'd13: begin ma = tmp;   mb = h1;       end
        5'd14: begin ma = tmp;   mb = ONE - h1; end
        default: begin
          if (!us[0]) begin ma = fdelta;     mb = finput; end
          else        begin ma = learn_rate; mb = tmp;    end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) w[i] <= seed(i);
      {tmp, h0, h1, y, dout, dh0, dh1, err} <= '0;
      busy <= 1'b0; done <= 1'b0; step <= '0; pat <= '0; epoch <= '0;
    end else if (!busy) begin
      if (start) begin
        for (int i = 0; i < 6; i++) w[i] <= seed(i);
        busy <= 1'b1; done <= 1'b0; step <= '0; pat <= '0; epoch <= '0; err <= '0;
      end
    end else begin
      step <= (step == 5'd26) ? 5'd0 : step + 5'd1;
      case (step)
        5'd0, 5'd2, 5'd4, 5'd7, 5'd9, 5'd10, 5'd12, 5'd13: tmp <= mres;
        5'd1:  h0   <= sig(sat(32'(tmp) + 32'(mres)));
        5'd3:  h1   <= sig(sat(32'(tmp) + 32'(mres)));
        5'd5:  y    <= sig(sat(32'(tmp) + 32'(mres)));
        5'd6:  err  <= sat(32'(err) + 32'(mres));
        5'd8:  dout <= mres;
        5'd11: dh0  <= mres;
        5'd14: dh1  <= mres;
        default: begin
          if (!us[0]) tmp <= mres;
          else        w[ui] <= sat(32'(w[ui]) + 32'(mres));
        end
      endcase
      if (step == 5'd26) begin
        pat <= pat + 2'd1;
        if (pat == 2'd3) begin
          epoch <= epoch + 1'b1;
          if (err < err_limit || epoch + 1'b1 == EW'(MAX_EPOCHS)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            err <= '0;
          end
        end
      end
    end
  end

  p_step_range_r10: assert property (@(posedge clk) disable iff (!rst_n) step <= 5'd26);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  p_done_at_pass_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(step == 5'd26 && pat == 2'd3));
  p_epoch_cap_r9: assert property (@(posedge clk) disable iff (!rst_n) epoch <= EW'(MAX_EPOCHS));
  p_err_nonneg_r6: assert property (@(posedge clk) disable iff (!rst_n) !err[15]);
  p_pat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(step) != 5'd26) |-> $stable(pat));
  p_idle_weights_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> ($stable(w[0]) && $stable(w[1]) && $stable(w[2])
                                 && $stable(w[3]) && $stable(w[4]) && $stable(w[5])));
endmodule

// File: tb/xor_bp_trainer_test.sv
`timescale 1ns/1ps
module xor_bp_trainer_test;
  localparam int MAXEP = 20;
  localparam int PCYC  = 108;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic signed [15:0] lr = 16'sd0, thr = 16'sd0;
  logic [2:0] addr = 3'd0;
  logic signed [15:0] rdata;
  logic done;
  int n_run = 0, n_fail = 0;
  int mw [6];
  int mep;

  always #5 clk = ~clk;

  xor_bp_trainer #(.MAX_EPOCHS(MAXEP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .learn_rate(lr), .err_limit(thr),
    .rd_addr(addr), .rd_data(rdata), .done(done));

  function automatic int seedv(input int i);
    case (i)
      0: return 2048; 1: return -1024; 2: return -1536;
      3: return 2867; 4: return 1229; default: return -819;
    endcase
  endfunction

  function automatic int clampq(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  // R3 product rule
  function automatic int mq(input int a, input int b);
    longint p;
    p = longint'(a) * longint'(b);
    return clampq(p >>> 12);
  endfunction

  // R4 sigmoid from bin centre
  function automatic int sg(input int s);
    int idx;
    real x;
    idx = (s >>> 10) + 32;
    x = (idx - 32) * 0.25 + 0.125;
    return $rtoi(4096.0 / (1.0 + $exp(-x)) + 0.5);
  endfunction

  task automatic model(input int lrv, input int thrv);
    int x0, x1, t, h0, h1, y, e, err, dout, dh0, dh1;
    for (int i = 0; i < 6; i++) mw[i] = seedv(i);
    mep = 0;
    forever begin
      err = 0;
      for (int p = 0; p < 4; p++) begin
        x0 = (p >> 1) ? 4096 : 0;
        x1 = (p & 1) ? 4096 : 0;
        t  = (((p >> 1) ^ (p & 1)) != 0) ? 4096 : 0;
        h0 = sg(clampq(mq(mw[0], x0) + mq(mw[1], x1)));
        h1 = sg(clampq(mq(mw[2], x0) + mq(mw[3], x1)));
        y  = sg(clampq(mq(mw[4], h0) + mq(mw[5], h1)));
        e  = t - y;
        err  = clampq(err + mq(e, e));
        dout = mq(mq(e, y), 4096 - y);
        dh0  = mq(mq(mq(mw[4], dout), h0), 4096 - h0);
        dh1  = mq(mq(mq(mw[5], dout), h1), 4096 - h1);
        mw[4] = clampq(mw[4] + mq(lrv, mq(dout, h0)));
        mw[5] = clampq(mw[5] + mq(lrv, mq(dout, h1)));
        mw[0] = clampq(mw[0] + mq(lrv, mq(dh0, x0)));
        mw[1] = clampq(mw[1] + mq(lrv, mq(dh0, x1)));
        mw[2] = clampq(mw[2] + mq(lrv, mq(dh1, x0)));
        mw[3] = clampq(mw[3] + mq(lrv, mq(dh1, x1)));
      end
      mep++;
      if (err < thrv || mep == MAXEP) break;
    end
  endtask

  task automatic chk(input string rq, input int act, input int expv);
    n_run++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, expv);
    end
  endtask

  task automatic read_w(input int i, output int v);
    addr = 3'(i);
    #1;
    v = int'(rdata);
  endtask

  task automatic run(input int lrv, input int thrv, input int glitch);
    int cyc, v;
    model(lrv, thrv);
    @(negedge clk);
    lr = 16'(lrv); thr = 16'(thrv); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    chk("R10 done cleared by start", int'(done), 0);
    while (!done && cyc < PCYC * MAXEP + 50) begin
      @(negedge clk);
      cyc++;
      start = (cyc == glitch);
      if (cyc == 1)
        for (int i = 0; i < 6; i++) begin
          read_w(i, v);
          chk($sformatf("R2 seed reload w%0d", i), v, seedv(i));
        end
    end
    start = 1'b0;
    chk("R10 R9 done cycle", cyc, PCYC * mep);
    for (int i = 0; i < 6; i++) begin
      read_w(i, v);
      chk($sformatf("R3 R4 R5 R6 R7 R8 trained w%0d", i), v, mw[i]);
    end
    repeat (5) @(negedge clk);
    chk("R10 done held", int'(done), 1);
    read_w(0, v);
    chk("R11 idle weight stable", v, mw[0]);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL R10 watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    int v;
    void'($urandom(32'd2417));
    repeat (3) @(negedge clk);
    chk("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", int'(done), 0);
    for (int i = 0; i < 8; i++) begin
      read_w(i, v);
      chk($sformatf("R1 reset weight %0d", i), v, (i < 6) ? seedv(i) : 0);
    end
    run(0, 0, 0);          // R8 zero rate: weights stay at seeds, full cap
    run(4096, 32767, 0);   // R9 large limit: one pass
    run(2048, 0, 0);       // R9 cap reached
    run(2048, 0, 37);      // R2 start during run ignored
    run(2048, -1, 250);    // R2 ignored start, negative limit
    run(30000, 0, 0);      // R3 saturation at large rate
    for (int k = 0; k < 5; k++) run(256 + int'($urandom % 12000), int'($urandom % 6000), 0);
    for (int i = 6; i < 8; i++) begin
      read_w(i, v);
      chk("R11 unused address", v, 0);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule